// File: doc/BRIEF.md
# Per-DRAM Addressability Mask Loader

This block prepares a DDR4 rank for per-DRAM-addressable mode-register writes and takes it back out. On an enable request it turns a 4-bit lane-select mask into a 32-bit data pattern and loads it into the on-die pattern generator. A selected lane drives its byte low and a deselected lane drives it high, so only the selected DRAMs latch the next mode-register command. It then sets the per-DRAM-addressability bit of mode register 3 and issues the mode-register command. It polls the controller's operation field until the field clears.

On a disable request it clears the mode-register bit and issues the command. Before it polls for completion, it waits for the pattern generator to report done. A disable is refused when the mode was never entered. Every register write leaves through one valid/ready write channel. The channel holds its target, data and bit mask stable until it is accepted, and the downstream side may stall it for any number of cycles. Requests are accepted only while the block is idle (`req_ready` high). Each request ends with a one-cycle response pulse that carries a result code.

Top module: `pda_mask_loader`

## Requirements
- R1: After reset `wr_valid` and `rsp_valid` are low, `req_ready` is high and `pda_active` is low.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from then until the response pulse has been given.
- R3: The pattern word has byte i (bits 8i+7:8i) equal to 0xFF when lane mask bit i is 0, and 0x00 when it is 1. A mask of 0xF gives an all-zero word.
- R4: An enable issues writes in this order, with targets encoded as control=0, pattern-low=1, pattern-high=2, pattern-address=3, buffer-offset=4, mode-register-3=5, operation=6. It writes control first. For each entry 0 to 3 it writes pattern-low (the word), pattern-high (the same word) and pattern-address (the entry number), each with an all-ones mask. It then writes buffer-offset with data 0 and mask all-ones, then mode-register-3, then operation.
- R5: The control write carries the chip select in bits 27:26, bit 25 set, the value 3 in the 6-bit field 16:11, the value 3 in the 6-bit field 10:5, and bit 0 set. Its mask is 0x0E01_FFE1.
- R6: The mode-register-3 write has mask 0x10 and data 0x10 on enable or 0 on disable. The operation write has mask 0xF1F and data 0xE09 for chip select 0 or 0xD09 for chip select 1.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_target`, `wr_data` and `wr_mask` hold their values into the next cycle.
- R8: A disable of an active rank issues only the mode-register-3 and operation writes. If `pg_done` is not seen within POLL_LIMIT cycles after the operation write, the response code is 2 (generator not done) and no completion polling takes place.
- R9: Completion polling ends with code 0 when `op_field` reads zero. If it has not read zero within POLL_LIMIT cycles, the code is 1 (timeout).
- R10: A disable while `pda_active` is low issues no write and responds with code 3.
- R11: `pda_active` rises only together with a code-0 response to an enable. It falls at the response of any disable that issued its writes. An enable that times out leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_enable | input | 1 | 1 enter per-DRAM mode, 0 leave it |
| req_cs | input | 1 | Chip select, 0 or 1 |
| req_lane_mask | input | 4 | Lane select, 1 = lane addressed |
| wr_valid | output | 1 | Register write present |
| wr_ready | input | 1 | Register write accepted |
| wr_target | output | 3 | Register target code |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Bits of the target that are written |
| op_field | input | 5 | Opcode field of the controller's operation register, zero when idle |
| pg_done | input | 1 | Pattern generator finished |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 2 | 0 ok, 1 timeout, 2 generator not done, 3 not active |
| pda_active | output | 1 | Rank is in per-DRAM mode |

## Verification
The assertions assume the request fields are stable only on the cycle they are taken, and that `op_field` and `pg_done` may change at any time. They assume nothing about how long `wr_ready` stays low. The stimulus draws `wr_ready` at random on every cycle, which exercises arbitrary back-pressure. It releases `op_field` and raises `pg_done` after random delays well below POLL_LIMIT, except in directed cases that hold them so the timeout and generator-failure paths run.

// File: rtl/pda_pkg.sv
package pda_pkg;

  typedef enum logic [2:0] {
    TGT_CTRL     = 3'd0,
    TGT_PAT_LO   = 3'd1,
    TGT_PAT_HI   = 3'd2,
    TGT_PAT_ADDR = 3'd3,
    TGT_BUF_OFFS = 3'd4,
    TGT_MODE3    = 3'd5,
    TGT_OPCMD    = 3'd6
  } wr_target_e;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_TIMEOUT  = 2'd1,
    RSP_PG_FAIL  = 2'd2,
    RSP_INACTIVE = 2'd3
  } rsp_code_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_LO, ST_HI, ST_ADDR, ST_OFFS,
    ST_MR3, ST_OP, ST_WAIT_PG, ST_POLL, ST_RESP
  } seq_state_e;

endpackage

// File: rtl/pda_pattern_gen.sv
module pda_pattern_gen #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   lane_mask,
  output logic [8*LANES-1:0] word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign word[8*i +: 8] = lane_mask[i] ? 8'h00 : 8'hFF;
  end
endmodule

// File: rtl/pda_poll_timer.sv
module pda_poll_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (step && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pda_write_seq.sv
module pda_write_seq
  import pda_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EW     = 2
) (
  input  seq_state_e        state,
  input  logic [EW-1:0]     entry,
  input  logic              cs,
  input  logic              enable,
  input  logic [DATA_W-1:0] pattern,
  output logic [2:0]        target,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] mask
);
  always_comb begin
    target = TGT_CTRL;
    data   = '0;
    mask   = '1;
    unique case (state)
      ST_CTRL: begin
        target       = TGT_CTRL;
        data[27:26]  = {1'b0, cs};
        data[25]     = 1'b1;
        data[16:11]  = 6'd3;
        data[10:5]   = 6'd3;
        data[0]      = 1'b1;
        mask         = '0;
        mask[27:25]  = 3'b111;
        mask[16:5]   = 12'hFFF;
        mask[0]      = 1'b1;
      end
      ST_LO:   begin target = TGT_PAT_LO; data = pattern; end
      ST_HI:   begin target = TGT_PAT_HI; data = pattern; end
      ST_ADDR: begin target = TGT_PAT_ADDR; data = {{(DATA_W-EW){1'b0}}, entry}; end
      ST_OFFS: begin target = TGT_BUF_OFFS; end
      ST_MR3: begin
        target  = TGT_MODE3;
        data[4] = enable;
        mask    = '0;
        mask[4] = 1'b1;
      end
      ST_OP: begin
        target     = TGT_OPCMD;
        data[11:8] = cs ? 4'hD : 4'hE;
        data[4:0]  = 5'h09;
        mask       = '0;
        mask[11:8] = 4'hF;
        mask[4:0]  = 5'h1F;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pda_mask_loader.sv
module pda_mask_loader
  import pda_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_ENTRIES = 4,
  parameter int POLL_LIMIT  = 64,
  parameter int OP_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_enable,
  input  logic              req_cs,
  input  logic [DATA_W/8-1:0] req_lane_mask,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [2:0]        wr_target,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_mask,
  input  logic [OP_W-1:0]   op_field,
  input  logic              pg_done,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              pda_active
);
  localparam int LANES = DATA_W / 8;
  localparam int EW    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  seq_state_e       state;
  logic [EW-1:0]    entry;
  logic             en_q, cs_q;
  logic [LANES-1:0] mask_q;
  logic [DATA_W-1:0] pattern;
  logic             hs, waiting, tmr_clear, tmr_step, expired;

  assign req_ready = (state == ST_IDLE);
  assign wr_valid  = (state inside {ST_CTRL, ST_LO, ST_HI, ST_ADDR, ST_OFFS, ST_MR3, ST_OP});
  assign hs        = wr_valid && wr_ready;
  assign rsp_valid = (state == ST_RESP);

  pda_pattern_gen #(.LANES(LANES)) u_pat (.lane_mask(mask_q), .word(pattern));

  pda_write_seq #(.DATA_W(DATA_W), .EW(EW)) u_seq (
    .state(state), .entry(entry), .cs(cs_q), .enable(en_q), .pattern(pattern),
    .target(wr_target), .data(wr_data), .mask(wr_mask)
  );

  assign waiting   = (state == ST_WAIT_PG) || (state == ST_POLL);
  assign tmr_clear = !waiting || ((state == ST_WAIT_PG) && pg_done);
  assign tmr_step  = waiting;

  pda_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .step(tmr_step), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      entry      <= '0;
      en_q       <= 1'b0;
      cs_q       <= 1'b0;
      mask_q     <= '0;
      rsp_code   <= RSP_OK;
      pda_active <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          en_q   <= req_enable;
          cs_q   <= req_cs;
          mask_q <= req_lane_mask;
          entry  <= '0;
          if (req_enable)       state <= ST_CTRL;
          else if (pda_active)  state <= ST_MR3;
          else begin
            rsp_code <= RSP_INACTIVE;
            state    <= ST_RESP;
          end
        end
        ST_CTRL: if (hs) state <= ST_LO;
        ST_LO:   if (hs) state <= ST_HI;
        ST_HI:   if (hs) state <= ST_ADDR;
        ST_ADDR: if (hs) begin
          if (entry == EW'(NUM_ENTRIES - 1)) state <= ST_OFFS;
          else begin
            entry <= entry + 1'b1;
            state <= ST_LO;
          end
        end
        ST_OFFS: if (hs) state <= ST_MR3;
        ST_MR3:  if (hs) state <= ST_OP;
        ST_OP:   if (hs) state <= en_q ? ST_POLL : ST_WAIT_PG;
        ST_WAIT_PG: begin
          if (pg_done) state <= ST_POLL;
          else if (expired) begin
            rsp_code   <= RSP_PG_FAIL;
            pda_active <= 1'b0;
            state      <= ST_RESP;
          end
        end
        ST_POLL: begin
          if (op_field == '0) begin
            rsp_code   <= RSP_OK;
            pda_active <= en_q;
            state      <= ST_RESP;
          end else if (expired) begin
            rsp_code <= RSP_TIMEOUT;
            if (!en_q) pda_active <= 1'b0;
            state    <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: write held stable under back-pressure
  a_r7_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_target) && $stable(wr_data) && $stable(wr_mask)));

  // R10: refused disable produces no write on the next cycle
  a_r10_no_write_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_enable && !pda_active) |=> (!wr_valid && rsp_valid && rsp_code == RSP_INACTIVE));

  // R2: no new request while a response is pending, and the pulse lasts one cycle
  a_r2_busy_during_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready ##1 !rsp_valid));

  // R3: a full lane mask loads an all-zero pattern
  a_r3_full_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_target == TGT_PAT_LO || wr_target == TGT_PAT_HI) && mask_q == '1) |-> (wr_data == '0));

  // R11: active only rises with a successful response
  a_r11_active_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pda_active) |-> (rsp_valid && rsp_code == RSP_OK));

  // R8: disable never touches the pattern buffer
  a_r8_disable_no_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !en_q) |-> (wr_target == TGT_MODE3 || wr_target == TGT_OPCMD));
endmodule

// File: tb/test_pda_mask_loader.sv
module test_pda_mask_loader;
  localparam int LIMIT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_enable = 0, req_cs = 0, wr_ready = 0, pg_done = 0;
  logic [3:0] req_lane_mask = 0;
  logic [4:0] op_field = 0;
  logic req_ready, wr_valid, rsp_valid, pda_active;
  logic [2:0] wr_target;
  logic [31:0] wr_data, wr_mask;
  logic [1:0] rsp_code;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pda_mask_loader #(.POLL_LIMIT(LIMIT)) i_pda_mask_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_enable(req_enable), .req_cs(req_cs), .req_lane_mask(req_lane_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_target(wr_target),
    .wr_data(wr_data), .wr_mask(wr_mask), .op_field(op_field), .pg_done(pg_done),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .pda_active(pda_active)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat_word(logic [3:0] m);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) if (!m[i]) w[8*i +: 8] = 8'hFF;
    return w;
  endfunction

  logic [2:0]  e_tgt[0:31];
  logic [31:0] e_dat[0:31], e_msk[0:31];
  int e_n;
  logic [2:0]  g_tgt[0:31];
  logic [31:0] g_dat[0:31], g_msk[0:31];
  int g_n;

  task automatic push(logic [2:0] t, logic [31:0] d, logic [31:0] m);
    e_tgt[e_n] = t; e_dat[e_n] = d; e_msk[e_n] = m; e_n++;
  endtask

  task automatic build_exp(bit en, bit cs, logic [3:0] m);
    e_n = 0;
    if (en) begin
      push(3'd0, {4'b0, 1'b0, cs, 1'b1, 8'b0, 6'd3, 6'd3, 4'b0, 1'b1}, 32'h0E01_FFE1);
      for (int k = 0; k < 4; k++) begin
        push(3'd1, pat_word(m), 32'hFFFF_FFFF);
        push(3'd2, pat_word(m), 32'hFFFF_FFFF);
        push(3'd3, 32'(k), 32'hFFFF_FFFF);
      end
      push(3'd4, 32'h0, 32'hFFFF_FFFF);
    end
    push(3'd5, en ? 32'h10 : 32'h0, 32'h10);
    push(3'd6, cs ? 32'hD09 : 32'hE09, 32'hF1F);
  endtask

  // one request; busy/pg are delays in cycles after the operation write
  task automatic run_op(bit en, bit cs, logic [3:0] m, int busy, int pgd,
                        logic [1:0] exp_code, bit exp_act, string tag);
    int busy_left = -1, pg_left = -1, guard = 0;
    bit saw_busy_ready = 0, got = 0;
    g_n = 0;
    build_exp(en, cs, m);
    if (!en && !pda_active) e_n = 0;
    if (exp_code == 2'd3) e_n = 0;
    @(negedge clk);
    req_valid = 1; req_enable = en; req_cs = cs; req_lane_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!got && guard < 1000) begin
      guard++;
      if (req_ready) saw_busy_ready = 1;
      if (busy_left > 0) busy_left--;
      if (pg_left > 0) pg_left--;
      op_field = (busy_left != 0 && busy_left != -1) ? 5'h09 : 5'h00;
      pg_done  = (pg_left == 0);
      wr_ready = 1'($urandom_range(0, 2) != 0);
      #1;
      if (rsp_valid) begin
        got = 1;
        chk({tag, " R9/R8/R10 code"}, 32'(rsp_code), 32'(exp_code));
      end else if (wr_valid && wr_ready) begin
        if (g_n < 32) begin
          g_tgt[g_n] = wr_target; g_dat[g_n] = wr_data; g_msk[g_n] = wr_mask;
        end
        g_n++;
        if (wr_target == 3'd6) begin busy_left = busy; pg_left = pgd; end
      end
      @(negedge clk);
    end
    wr_ready = 0; op_field = 0; pg_done = 0;
    chk({tag, " R2 ready low while busy"}, 32'(saw_busy_ready), 32'd0);
    chk({tag, " R4 write count"}, 32'(g_n), 32'(e_n));
    for (int i = 0; i < e_n && i < g_n; i++) begin
      chk({tag, " R4 target"}, 32'(g_tgt[i]), 32'(e_tgt[i]));
      chk({tag, (e_tgt[i] == 3'd0) ? " R5 data" : (e_tgt[i] >= 3'd5) ? " R6 data" : " R3 data"},
          g_dat[i], e_dat[i]);
      chk({tag, " R5/R6 mask"}, g_msk[i], e_msk[i]);
    end
    #1;
    chk({tag, " R11 active"}, 32'(pda_active), 32'(exp_act));
    chk({tag, " R2 ready after"}, 32'(req_ready), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_valid", 32'(wr_valid), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 pda_active", 32'(pda_active), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_op(0, 0, 4'h5, 0, 0, 2'd3, 0, "R10 disable inactive");
    run_op(1, 0, 4'hF, 3, 0, 2'd0, 1, "R3 full mask");
    run_op(0, 0, 4'hF, 2, 4, 2'd0, 0, "R8 disable ok");
    run_op(1, 1, 4'h0, 0, 0, 2'd0, 1, "R3 empty mask");
    run_op(0, 1, 4'h0, 5, 0, 2'd0, 0, "R8 disable pg immediate");
    for (int it = 0; it < 8; it++) begin
      logic [3:0] m = 4'($urandom_range(0, 15));
      bit cs = 1'($urandom_range(0, 1));
      run_op(1, cs, m, $urandom_range(0, 30), 0, 2'd0, 1, "R4 random enable");
      run_op(0, cs, m, $urandom_range(0, 30), $urandom_range(0, 30), 2'd0, 0, "R8 random disable");
    end
    run_op(1, 0, 4'h6, 100000, 0, 2'd1, 0, "R9 enable timeout");
    run_op(1, 1, 4'h9, 1, 0, 2'd0, 1, "R11 enable");
    run_op(0, 1, 4'h9, 0, 100000, 2'd2, 0, "R8 pg not done");
    run_op(0, 0, 4'h1, 0, 0, 2'd3, 0, "R10 second disable");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule